// File: doc/BRIEF.md
# Mixed-Page-Size Translation Lookaside Buffer

This block is a fully associative address translation cache sitting between a processor's load/store path and the memory system. Each of its entries holds one mapping from a virtual region to a physical region. Each entry records its own region size: a 4 KB small page, an 8 KB large page or a 1 MB section. The compare mask and the address merge therefore change from one entry to the next.

A lookup presents a virtual address. One clock later the block returns a hit flag, the physical address and the cacheable and bufferable attributes of the mapping. An external table-walk agent writes complete entries through the fill port. The victim slot is picked by a rotating pointer. Two maintenance commands are provided. The first clears the whole buffer. The second clears only the mappings that cover a given address.

Top module: `mptlb`

## Requirements
- R1: After reset no entry is valid, so every lookup misses and `respValid` is 0 until a lookup is requested.
- R2: A lookup requested in cycle N is answered in cycle N+1. `respValid` is 1 in that cycle only, and `hit`, `physAddr`, `cacheable` and `bufferable` are valid with it.
- R3: The size code `fillSize` is encoded as follows. 2'b00 is a 4 KB page, compared on VA[31:12]. 2'b01 is an 8 KB page, compared on VA[31:13]. 2'b10 is a 1 MB section, compared on VA[31:20]. The VA bits below the compared range are ignored.
- R4: On a hit, `physAddr` takes its bits above the page offset from the entry's physical frame. It takes the offset bits (12, 13 or 20 of them) from the lookup address. The frame bits that fall inside the offset are ignored.
- R5: On a hit, the C and B bits stored with the winning entry are returned. On a miss, `physAddr`, `cacheable` and `bufferable` are all 0.
- R6: Fills are written to slots 0, 1, 2, … in turn and wrap from the last slot back to 0. A fill overwrites its slot whether or not that slot is valid.
- R7: A flush-all clears every entry and returns the fill pointer to slot 0. A fill presented in the same cycle is discarded and does not advance the pointer.
- R8: A flush-entry clears every valid entry whose mapping covers `flushVa` and leaves all other entries intact. A fill in the same cycle is still written.
- R9: When several valid entries cover the lookup address, the result comes from the lowest-numbered slot.
- R10: A lookup is resolved against the buffer contents held before the clock edge on which it is sampled. A fill or flush in that same cycle does not affect it.
- R11: Size code 2'b11 is reserved, and an entry filled with it never produces a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request strobe |
| lookupVa | input | 32 | Virtual address to translate |
| respValid | output | 1 | Lookup result valid (one cycle after request) |
| hit | output | 1 | A valid mapping covered the address |
| physAddr | output | 32 | Translated address, 0 on miss |
| cacheable | output | 1 | C attribute of the hit entry |
| bufferable | output | 1 | B attribute of the hit entry |
| fillValid | input | 1 | Write one entry at the round-robin slot |
| fillVa | input | 32 | Virtual base of the new mapping |
| fillPa | input | 32 | Physical base of the new mapping |
| fillSize | input | 2 | Size code (00 4 KB, 01 8 KB, 10 1 MB, 11 reserved) |
| fillCacheable | input | 1 | C attribute to store |
| fillBufferable | input | 1 | B attribute to store |
| flushAll | input | 1 | Invalidate all entries, reset pointer |
| flushOne | input | 1 | Invalidate entries covering flushVa |
| flushVa | input | 32 | Address for single-entry invalidation |

## Verification
The pointer reset on flush-all cannot be seen directly. It only shows up when the pointer sits at the last slot before the flush. The bench therefore performs enough fills to park the pointer at slot 31, then issues the flush together with a fill that must be discarded. It then fills two different translations for the same address. Only a pointer that restarted at 0 places the first of them in the lower slot, where it wins the lookup. Overlapping section and page mappings are also stacked on one address, so that priority and multi-entry flush both show in the result.

// File: rtl/mptlb_pkg.sv
package mptlb_pkg;

  typedef enum logic [1:0] {
    PG_4K  = 2'b00,
    PG_8K  = 2'b01,
    PG_1M  = 2'b10,
    PG_RSV = 2'b11
  } pageSizeE;

  typedef struct packed {
    logic fillEn;
    logic flushAllEn;
    logic flushOneEn;
  } tlbStrobeS;

endpackage

// File: rtl/mptlb_ctrl.sv
module mptlb_ctrl
  import mptlb_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       fillValidI,
  input  logic                       flushAllI,
  input  logic                       flushOneI,
  output tlbStrobeS                  strobesO,
  output logic [$clog2(ENTRIES)-1:0] victimO
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptrQ;

  // flush-all dominates: it suppresses both fill and single flush
  always_comb begin
    strobesO.flushAllEn = flushAllI;
    strobesO.fillEn     = fillValidI & ~flushAllI;
    strobesO.flushOneEn = flushOneI & ~flushAllI;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (flushAllI) begin
      ptrQ <= '0;
    end else if (fillValidI) begin
      ptrQ <= (ptrQ == LAST_IDX) ? '0 : ptrQ + 1'b1;
    end
  end

  assign victimO = ptrQ;

  // R7: the slot chosen after a flush-all is slot 0
  p_ptr_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    flushAllI |=> (victimO == '0));

  // R6: the pointer wraps from the last slot to slot 0
  p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobesO.fillEn && victimO == LAST_IDX) |=> (victimO == '0));

endmodule

// File: rtl/mptlb_datapath.sv
module mptlb_datapath
  import mptlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  tlbStrobeS                  strobesI,
  input  logic [$clog2(ENTRIES)-1:0] victimI,
  input  logic                       lookupValidI,
  input  logic [ADDR_W-1:0]          lookupVaI,
  input  logic [ADDR_W-1:0]          fillVaI,
  input  logic [ADDR_W-1:0]          fillPaI,
  input  logic [1:0]                 fillSizeI,
  input  logic                       fillCacheI,
  input  logic                       fillBufI,
  input  logic [ADDR_W-1:0]          flushVaI,
  output logic                       respValidO,
  output logic                       hitO,
  output logic [ADDR_W-1:0]          physAddrO,
  output logic                       cacheO,
  output logic                       bufO
);

  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int SMALL_OFF = 12;
  localparam int LARGE_OFF = 13;
  localparam int SECT_OFF  = 20;
  localparam int FRAME_W   = ADDR_W - SMALL_OFF;

  // frame mask: ones where bits take part in the compare / come from the entry
  function automatic logic [FRAME_W-1:0] frameMask(input logic [1:0] sz);
    logic [FRAME_W-1:0] m;
    case (sz)
      PG_8K:   m = {FRAME_W{1'b1}} << (LARGE_OFF - SMALL_OFF);
      PG_1M:   m = {FRAME_W{1'b1}} << (SECT_OFF - SMALL_OFF);
      default: m = {FRAME_W{1'b1}};
    endcase
    return m;
  endfunction

  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] cacheQ;
  logic [ENTRIES-1:0] bufQ;
  logic [FRAME_W-1:0] vpnQ  [ENTRIES];
  logic [FRAME_W-1:0] pfnQ  [ENTRIES];
  logic [1:0]         sizeQ [ENTRIES];

  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] flMatch;
  logic [ENTRIES-1:0] winVec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [FRAME_W-1:0] cmpMask;
    logic               usable;
    assign cmpMask    = frameMask(sizeQ[i]);
    assign usable     = validQ[i] & (sizeQ[i] != PG_RSV);
    assign lkMatch[i] = usable &
      (((lookupVaI[ADDR_W-1:SMALL_OFF] ^ vpnQ[i]) & cmpMask) == '0);
    assign flMatch[i] = usable &
      (((flushVaI[ADDR_W-1:SMALL_OFF] ^ vpnQ[i]) & cmpMask) == '0);
  end

  // lowest-index match wins
  assign winVec = lkMatch & (~lkMatch + ENTRIES'(1));

  logic [FRAME_W-1:0] selPfn;
  logic [1:0]         selSize;
  logic               selC;
  logic               selB;
  logic [FRAME_W-1:0] selMask;
  logic [ADDR_W-1:0]  paNext;
  logic               anyHit;

  always_comb begin
    selPfn  = '0;
    selSize = '0;
    selC    = 1'b0;
    selB    = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (winVec[i]) begin
        selPfn  = selPfn | pfnQ[i];
        selSize = selSize | sizeQ[i];
        selC    = selC | cacheQ[i];
        selB    = selB | bufQ[i];
      end
    end
    selMask = frameMask(selSize);
    paNext  = {(selPfn & selMask) | (lookupVaI[ADDR_W-1:SMALL_OFF] & ~selMask),
               lookupVaI[SMALL_OFF-1:0]};
    anyHit  = |lkMatch;
  end

  // valid bits: flush-all, then single flush, then fill (fill wins on same slot)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (strobesI.flushAllEn) begin
      validQ <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobesI.flushOneEn && flMatch[i]) validQ[i] <= 1'b0;
        if (strobesI.fillEn && victimI == IDX_W'(i)) validQ[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobesI.fillEn) begin
      vpnQ[victimI]   <= fillVaI[ADDR_W-1:SMALL_OFF];
      pfnQ[victimI]   <= fillPaI[ADDR_W-1:SMALL_OFF];
      sizeQ[victimI]  <= fillSizeI;
      cacheQ[victimI] <= fillCacheI;
      bufQ[victimI]   <= fillBufI;
    end
  end

  // registered lookup result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValidO <= 1'b0;
      hitO       <= 1'b0;
      physAddrO  <= '0;
      cacheO     <= 1'b0;
      bufO       <= 1'b0;
    end else begin
      respValidO <= lookupValidI;
      hitO       <= lookupValidI & anyHit;
      physAddrO  <= (lookupValidI & anyHit) ? paNext : '0;
      cacheO     <= lookupValidI & anyHit & selC;
      bufO       <= lookupValidI & anyHit & selB;
    end
  end

  // R7: a flush-all strobe from control leaves no valid entry
  p_flush_all_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobesI.flushAllEn |=> (validQ == '0));

  // R6: the victim slot chosen by control holds a valid entry after a fill
  p_fill_marks_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobesI.fillEn |=> validQ[$past(victimI)]);

  // R8: a single flush without a fill never grows the valid population
  p_flush_one_shrinks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobesI.flushOneEn && !strobesI.fillEn) |=>
      ($countones(validQ) <= $past($countones(validQ))));

  // R1: a hit needs at least one valid entry in the request cycle
  p_hit_needs_entry_r1: assert property (@(posedge clk) disable iff (!rstN)
    hitO |-> $past(validQ != '0));

  // R2: every request is answered on the following edge
  p_resp_next_cycle_r2: assert property (@(posedge clk) disable iff (!rstN)
    lookupValidI |=> respValidO);

endmodule

// File: rtl/mptlb.sv
module mptlb
  import mptlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupVa,
  output logic              respValid,
  output logic              hit,
  output logic [ADDR_W-1:0] physAddr,
  output logic              cacheable,
  output logic              bufferable,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillVa,
  input  logic [ADDR_W-1:0] fillPa,
  input  logic [1:0]        fillSize,
  input  logic              fillCacheable,
  input  logic              fillBufferable,
  input  logic              flushAll,
  input  logic              flushOne,
  input  logic [ADDR_W-1:0] flushVa
);

  localparam int IDX_W = $clog2(ENTRIES);

  tlbStrobeS        strobes;
  logic [IDX_W-1:0] victim;

  mptlb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fillValidI (fillValid),
    .flushAllI  (flushAll),
    .flushOneI  (flushOne),
    .strobesO   (strobes),
    .victimO    (victim)
  );

  mptlb_datapath #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobesI     (strobes),
    .victimI      (victim),
    .lookupValidI (lookupValid),
    .lookupVaI    (lookupVa),
    .fillVaI      (fillVa),
    .fillPaI      (fillPa),
    .fillSizeI    (fillSize),
    .fillCacheI   (fillCacheable),
    .fillBufI     (fillBufferable),
    .flushVaI     (flushVa),
    .respValidO   (respValid),
    .hitO         (hit),
    .physAddrO    (physAddr),
    .cacheO       (cacheable),
    .bufO         (bufferable)
  );

endmodule

// File: tb/mptlb_tb.sv
`timescale 1ns/1ps
module mptlb_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        lookupValid;
  logic [31:0] lookupVa;
  logic        respValid;
  logic        hit;
  logic [31:0] physAddr;
  logic        cacheable;
  logic        bufferable;
  logic        fillValid;
  logic [31:0] fillVa;
  logic [31:0] fillPa;
  logic [1:0]  fillSize;
  logic        fillCacheable;
  logic        fillBufferable;
  logic        flushAll;
  logic        flushOne;
  logic [31:0] flushVa;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mptlb u_dut (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupVa(lookupVa),
    .respValid(respValid), .hit(hit), .physAddr(physAddr),
    .cacheable(cacheable), .bufferable(bufferable),
    .fillValid(fillValid), .fillVa(fillVa), .fillPa(fillPa),
    .fillSize(fillSize), .fillCacheable(fillCacheable),
    .fillBufferable(fillBufferable),
    .flushAll(flushAll), .flushOne(flushOne), .flushVa(flushVa)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearInputs;
    lookupValid = 0; lookupVa = '0;
    fillValid = 0; fillVa = '0; fillPa = '0; fillSize = '0;
    fillCacheable = 0; fillBufferable = 0;
    flushAll = 0; flushOne = 0; flushVa = '0;
  endtask

  task automatic setFill(input logic [31:0] va, input logic [31:0] pa,
                         input logic [1:0] sz, input logic c, input logic b);
    fillValid = 1; fillVa = va; fillPa = pa; fillSize = sz;
    fillCacheable = c; fillBufferable = b;
  endtask

  task automatic doFill(input logic [31:0] va, input logic [31:0] pa,
                        input logic [1:0] sz, input logic c, input logic b);
    @(negedge clk); setFill(va, pa, sz, c, b);
    @(negedge clk); fillValid = 0;
  endtask

  task automatic doFlushAll;
    @(negedge clk); flushAll = 1;
    @(negedge clk); flushAll = 0;
  endtask

  task automatic doFlushOne(input logic [31:0] va);
    @(negedge clk); flushOne = 1; flushVa = va;
    @(negedge clk); flushOne = 0;
  endtask

  task automatic expectHit(input logic [31:0] va, input logic [31:0] pa,
                           input logic c, input logic b, input string req);
    @(negedge clk); lookupValid = 1; lookupVa = va;
    @(negedge clk); lookupValid = 0;
    chk(respValid === 1'b1, {req, " respValid"}, {31'd0, respValid}, 32'd1);
    chk(hit === 1'b1, {req, " hit"}, {31'd0, hit}, 32'd1);
    chk(physAddr === pa, {req, " physAddr"}, physAddr, pa);
    chk({cacheable, bufferable} === {c, b}, {req, " C/B"},
        {30'd0, cacheable, bufferable}, {30'd0, c, b});
  endtask

  task automatic expectMiss(input logic [31:0] va, input string req);
    @(negedge clk); lookupValid = 1; lookupVa = va;
    @(negedge clk); lookupValid = 0;
    chk(respValid === 1'b1, {req, " respValid"}, {31'd0, respValid}, 32'd1);
    chk(hit === 1'b0, {req, " miss"}, {31'd0, hit}, 32'd0);
    chk({physAddr, cacheable, bufferable} === 34'd0, {req, " R5 zero on miss"},
        physAddr, 32'd0);
  endtask

  // R1, R2: reset state and idle response
  task automatic testReset;
    chk(respValid === 1'b0, "R1 respValid after reset", {31'd0, respValid}, 32'd0);
    expectMiss(32'h0000_0000, "R1 empty");
    expectMiss(32'h1234_5678, "R1 empty");
    @(negedge clk);
    chk(respValid === 1'b0, "R2 respValid drops", {31'd0, respValid}, 32'd0);
  endtask

  // R3, R4, R5, R11: each size code
  task automatic testSizes;
    doFill(32'h1234_5000, 32'h8765_4000, 2'b00, 1, 0);
    expectHit(32'h1234_5ABC, 32'h8765_4ABC, 1, 0, "R3 R4 4KB");
    expectMiss(32'h1234_4ABC, "R3 4KB neighbour");
    doFill(32'h4000_3000, 32'h9000_1000, 2'b01, 0, 1);
    expectHit(32'h4000_2F10, 32'h9000_0F10, 0, 1, "R3 R4 8KB low half");
    expectHit(32'h4000_3F10, 32'h9000_1F10, 0, 1, "R4 8KB high half");
    expectMiss(32'h4000_4000, "R3 8KB neighbour");
    doFill(32'hC030_0000, 32'h0AB5_5000, 2'b10, 1, 1);
    expectHit(32'hC03F_FFFC, 32'h0ABF_FFFC, 1, 1, "R3 R4 R5 1MB");
    expectMiss(32'hC040_0000, "R3 1MB neighbour");
    doFill(32'h7000_0000, 32'h7100_0000, 2'b11, 1, 1);
    expectMiss(32'h7000_0000, "R11 reserved size");
  endtask

  // R9 priority, R8 multi-entry flush
  task automatic testPriorityFlushOne;
    doFlushAll();
    doFill(32'h2000_0000, 32'h3100_0000, 2'b10, 0, 0);  // slot 0
    doFill(32'h2000_1000, 32'h5555_5000, 2'b00, 1, 1);  // slot 1
    doFill(32'h6000_0000, 32'h6100_0000, 2'b00, 1, 0);  // slot 2
    expectHit(32'h2000_1234, 32'h3100_1234, 0, 0, "R9 lowest slot");
    doFlushOne(32'h2000_1800);
    expectMiss(32'h2000_1234, "R8 both covering cleared");
    expectMiss(32'h2000_5000, "R8 section cleared");
    expectHit(32'h6000_0004, 32'h6100_0004, 1, 0, "R8 other untouched");
  endtask

  // R6: round-robin order and wrap
  task automatic testRoundRobin;
    doFlushAll();
    for (int i = 0; i < 32; i++)
      doFill(32'h1000_0000 + (i << 12), 32'hA000_0000 + (i << 12), 2'b00, 0, 0);
    for (int i = 0; i < 32; i++)
      expectHit(32'h1000_0010 + (i << 12), 32'hA000_0010 + (i << 12), 0, 0,
                "R6 all slots");
    doFill(32'h1F00_0000, 32'hBB00_0000, 2'b00, 1, 0);
    expectMiss(32'h1000_0000, "R6 wrap evicts slot 0");
    expectHit(32'h1000_1000, 32'hA000_1000, 0, 0, "R6 slot 1 kept");
    expectHit(32'h1F00_0000, 32'hBB00_0000, 1, 0, "R6 new entry");
    doFill(32'h1F10_0000, 32'hBB10_0000, 2'b00, 0, 1);
    expectMiss(32'h1000_1000, "R6 next evicts slot 1");
    expectHit(32'h1000_2000, 32'hA000_2000, 0, 0, "R6 slot 2 kept");
  endtask

  // R7: pointer restart and discarded fill
  task automatic testFlushAll;
    // pointer is at 2 here; 29 more fills park it at slot 31
    for (int i = 0; i < 29; i++)
      doFill(32'h3000_0000 + (i << 12), 32'h3000_0000, 2'b00, 0, 0);
    @(negedge clk);
    flushAll = 1;
    setFill(32'h5500_0000, 32'h5600_0000, 2'b00, 1, 1);
    @(negedge clk); flushAll = 0; fillValid = 0;
    expectMiss(32'h5500_0000, "R7 fill with flush-all dropped");
    expectMiss(32'h1F00_0000, "R7 earlier entries gone");
    expectMiss(32'h3000_0000, "R7 earlier entries gone");
    doFill(32'h7700_0000, 32'h1100_0000, 2'b00, 1, 0);
    doFill(32'h7700_0000, 32'h2200_0000, 2'b00, 0, 1);
    expectHit(32'h7700_0040, 32'h1100_0040, 1, 0, "R7 pointer restarted at 0");
  endtask

  // R10, R8: same-cycle interactions
  task automatic testSameCycle;
    @(negedge clk);
    lookupValid = 1; lookupVa = 32'h8800_0000;
    setFill(32'h8800_0000, 32'h9900_0000, 2'b00, 0, 0);
    @(negedge clk); lookupValid = 0; fillValid = 0;
    chk(hit === 1'b0, "R10 lookup sees old contents", {31'd0, hit}, 32'd0);
    expectHit(32'h8800_0008, 32'h9900_0008, 0, 0, "R10 fill visible next");
    @(negedge clk);
    flushOne = 1; flushVa = 32'h8800_0000;
    setFill(32'h8A00_0000, 32'h9A00_0000, 2'b10, 1, 1);
    @(negedge clk); flushOne = 0; fillValid = 0;
    expectMiss(32'h8800_0008, "R8 flushed with fill");
    expectHit(32'h8A0F_0000, 32'h9A0F_0000, 1, 1, "R8 fill kept beside flush");
  endtask

  initial begin
    clearInputs();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testSizes();
    testPriorityFlushOne();
    testRoundRobin();
    testFlushAll();
    testSameCycle();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule